// File: doc/BRIEF.md
# Line Sensor Readout Sequencer

This block produces the complete control waveform for one readout frame of a clocked line-scan sensor and the ADC that digitises its pixels. One pulse on `start` launches a frame. The sequencer first clears all control lines, then releases the sensor reset, then opens and closes two gate lines. It then issues two plain shift-clock pulses and one clock group per pixel. Each group opens with an ADC conversion strobe inside the shift-clock low time. A trailing strobe converts the last pixel. A sample/hold window follows, and a one-cycle `done` pulse closes the frame.

All timing is counted in a base tick of `TICK_CYC` clock cycles. The strobe lasts `STROBE_CYC` cycles, which must be less than one tick. The number of pixel groups is `PIXELS`, and the second gate line stays open for the first `GATE_B_GROUPS` of them. Every output comes from a register. A frame of `PIXELS` groups lasts (57 + 8·PIXELS) ticks, counted from the clock edge that samples `start` to the edge that raises `done`.

Top module: `lsq_readout_seq`

## Requirements
- R1: Under synchronous reset (`rst_n` low at a clock edge), `sns_rst`, `gate_a`, `gate_b`, `adc_go`, `hold` and `done` are 0 and `shift_clk` is 1 from that edge on. This holds even when a frame is running.
- R2: At the edge that samples `start` high in idle, all lines except `shift_clk` go to 0 and `shift_clk` stays 1. `sns_rst` rises 2 ticks later and stays 1 until the next frame or reset.
- R3: `gate_a` and `gate_b` rise together 8 ticks after the frame begins. `gate_a` falls alone 8 ticks later. `gate_a` is never 1 while `gate_b` is 0.
- R4: `shift_clk` pulses low for exactly 1 tick and is then high for 3 ticks. Two such plain pulses start 24 ticks into the frame. Each pixel group is 8 ticks long and contains two of these low/high pairs.
- R5: Each pixel group starts with `shift_clk` falling and `adc_go` rising in the same cycle. `adc_go` is 1 for exactly `STROBE_CYC` cycles.
- R6: A frame contains exactly `PIXELS`+1 `adc_go` pulses: one per group and one trailing pulse.
- R7: `gate_b` falls at the start of group number `GATE_B_GROUPS`+1, in the same cycle as that group's strobe. It stays 0 for the rest of the frame.
- R8: The trailing strobe begins 8 ticks after the last group begins, with `shift_clk` high. `hold` rises 17 ticks after that strobe begins, stays 1 for 4 ticks, and never overlaps `gate_a`, `gate_b` or `adc_go`.
- R9: `done` is 1 for exactly one cycle, 4 ticks after `hold` falls. At that time `sns_rst` and `shift_clk` are 1.
- R10: From the `start` edge to the `done` edge, a frame takes (57 + 8·PIXELS)·TICK_CYC cycles, and no output changes outside the edges listed above.
- R11: `start` is ignored while a frame is running. The waveform and the frame length stay the same.
- R12: A new `start` after `done` runs the whole frame again from initialisation. The first event is `sns_rst` falling at the `start` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a frame when seen high in idle |
| sns_rst | output | 1 | Sensor reset release, 1 = released |
| gate_a | output | 1 | First transfer gate control |
| gate_b | output | 1 | Second transfer gate control |
| shift_clk | output | 1 | Pixel shift clock, idles high |
| adc_go | output | 1 | ADC start-conversion strobe |
| hold | output | 1 | Sample/hold strobe |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The hardest thing to reach from the ports is the single group boundary where `gate_b` falls. It has to coincide with the strobe and the clock fall of group `GATE_B_GROUPS`+1, after the internal pixel count has passed a value that no port shows. The bench gets there by running complete frames with a short tick, so each run passes through every group boundary. A scoreboard predicts every output edge of the frame with its cycle offset, and any off-by-one in the count shows up as an out-of-order or mistimed edge. A stray `start` in mid-frame and a reset in mid-frame cover the ignore and recovery cases.

// File: rtl/lsq_pkg.sv
// Package: shared phase encoding and control-line bundle of the readout
// sequencer. Assumes the line bundle is always driven from registers.
package lsq_pkg;

    typedef enum logic [4:0] {
        PH_IDLE,
        PH_INIT,    // all lines cleared, waiting before reset release
        PH_RSTW,    // reset released, settling
        PH_BOTH,    // both gates open
        PH_AOFF,    // first gate closed
        PH_PLO,     // plain pulse, clock low
        PH_PHI,     // plain pulse, clock high
        PH_GSTB,    // group: clock low with strobe
        PH_GLO,     // group: clock low, strobe done
        PH_GHI,     // group: clock high
        PH_GPLO,    // group trailing pulse, clock low
        PH_GPHI,    // group trailing pulse, clock high
        PH_TSTB,    // trailing strobe
        PH_TREST,   // rest of trailing tick
        PH_TWAIT,   // idle wait before hold
        PH_HOLDH,   // hold high
        PH_HOLDL    // hold low
    } phase_e;

    typedef struct packed {
        logic rst;
        logic ga;
        logic gb;
        logic sclk;
        logic adc;
        logic hold;
    } lines_t;

    localparam lines_t LINES_RESET = '{rst: 1'b0, ga: 1'b0, gb: 1'b0,
                                       sclk: 1'b1, adc: 1'b0, hold: 1'b0};

    // Map a phase onto the lines it drives; gb is kept from cur (owned by the driver).
    function automatic lines_t decode_lines(phase_e p, lines_t cur);
        lines_t l;
        l = cur;
        if (p != PH_IDLE) begin
            l.rst  = (p != PH_INIT);
            l.ga   = (p == PH_BOTH);
            l.sclk = !(p == PH_PLO || p == PH_GSTB || p == PH_GLO || p == PH_GPLO);
            l.adc  = (p == PH_GSTB || p == PH_TSTB);
            l.hold = (p == PH_HOLDH);
        end
        return l;
    endfunction

endpackage

// File: rtl/lsq_tick_timer.sv
// Segment timer: loads a cycle count on each phase change and counts down.
// Assumes the loaded value is the segment length minus one; expire is
// high in the last cycle of the segment.
module lsq_tick_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expire
);

    logic [CW-1:0] cnt;

    // Down-counter reloaded at every phase entry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expire = (cnt == '0);

endmodule

// File: rtl/lsq_pixel_counter.sv
// Pixel group counter: preloaded with the group count at frame start,
// decremented as each group begins. Flags the last group and the group
// boundary where the second gate closes.
module lsq_pixel_counter #(
    parameter int PIXELS        = 128,
    parameter int GATE_B_GROUPS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic preload,
    input  logic step,
    output logic last,
    output logic gate_cut
);

    localparam int PW = $clog2(PIXELS + 1);
    localparam logic [PW-1:0] CUT_VAL  = PW'(PIXELS - GATE_B_GROUPS);
    localparam logic [PW-1:0] LOAD_VAL = PW'(PIXELS);

    logic [PW-1:0] cnt;

    // Remaining-groups register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (preload)
            cnt <= LOAD_VAL;
        else if (step && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last     = (cnt == '0);
    assign gate_cut = (cnt == CUT_VAL);

endmodule

// File: rtl/lsq_phase_fsm.sv
// Phase sequencer: steps the frame through its phases. A phase ends when
// the segment timer expires. It gives the timer the length of the next phase.
// Assumes STROBE_CYC < TICK_CYC so no segment has zero length.
module lsq_phase_fsm
    import lsq_pkg::*;
#(
    parameter int TICK_CYC   = 525,
    parameter int STROBE_CYC = 50,
    parameter int CW         = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          expire,
    input  logic          pix_last,
    output phase_e        ph,
    output phase_e        ph_nxt,
    output logic          adv,
    output logic [CW-1:0] load_val
);

    logic pl_second;

    // Segment length in cycles of a phase.
    function automatic int unsigned len_of(phase_e p);
        case (p)
            PH_INIT:             return 2 * TICK_CYC;
            PH_RSTW:             return 6 * TICK_CYC;
            PH_BOTH, PH_AOFF:    return 8 * TICK_CYC;
            PH_PLO, PH_GPLO:     return TICK_CYC;
            PH_PHI, PH_GHI,
            PH_GPHI:             return 3 * TICK_CYC;
            PH_GSTB, PH_TSTB:    return STROBE_CYC;
            PH_GLO, PH_TREST:    return TICK_CYC - STROBE_CYC;
            PH_TWAIT:            return 16 * TICK_CYC;
            PH_HOLDH, PH_HOLDL:  return 4 * TICK_CYC;
            default:             return 1;
        endcase
    endfunction

    // Next-phase selection; start is only looked at in idle.
    always_comb begin
        ph_nxt = ph;
        case (ph)
            PH_IDLE:  if (start)  ph_nxt = PH_INIT;
            PH_INIT:  if (expire) ph_nxt = PH_RSTW;
            PH_RSTW:  if (expire) ph_nxt = PH_BOTH;
            PH_BOTH:  if (expire) ph_nxt = PH_AOFF;
            PH_AOFF:  if (expire) ph_nxt = PH_PLO;
            PH_PLO:   if (expire) ph_nxt = PH_PHI;
            PH_PHI:   if (expire) ph_nxt = pl_second ? PH_GSTB : PH_PLO;
            PH_GSTB:  if (expire) ph_nxt = PH_GLO;
            PH_GLO:   if (expire) ph_nxt = PH_GHI;
            PH_GHI:   if (expire) ph_nxt = PH_GPLO;
            PH_GPLO:  if (expire) ph_nxt = PH_GPHI;
            PH_GPHI:  if (expire) ph_nxt = pix_last ? PH_TSTB : PH_GSTB;
            PH_TSTB:  if (expire) ph_nxt = PH_TREST;
            PH_TREST: if (expire) ph_nxt = PH_TWAIT;
            PH_TWAIT: if (expire) ph_nxt = PH_HOLDH;
            PH_HOLDH: if (expire) ph_nxt = PH_HOLDL;
            PH_HOLDL: if (expire) ph_nxt = PH_IDLE;
            default:              ph_nxt = PH_IDLE;
        endcase
    end

    assign adv      = (ph_nxt != ph);
    assign load_val = CW'(len_of(ph_nxt) - 1);

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ph <= PH_IDLE;
        else
            ph <= ph_nxt;
    end

    // Marks that the first of the two plain clock pulses is done.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pl_second <= 1'b0;
        else if (adv && ph_nxt == PH_INIT)
            pl_second <= 1'b0;
        else if (adv && ph == PH_PHI)
            pl_second <= 1'b1;
    end

endmodule

// File: rtl/lsq_line_driver.sv
// Output stage: registers every control line from the phase being entered,
// so the lines change in the same cycle the phase does. It owns the second
// gate line, which depends on the pixel count. It also produces the
// end-of-frame pulse.
module lsq_line_driver
    import lsq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_e ph,
    input  phase_e ph_nxt,
    input  logic   adv,
    input  logic   gate_cut,
    output lines_t lines,
    output logic   done
);

    lines_t nxt;

    // Decode the entered phase; open or close the second gate at its boundaries.
    always_comb begin
        nxt = decode_lines(ph_nxt, lines);
        if (adv && ph_nxt == PH_INIT)
            nxt.gb = 1'b0;
        else if (adv && ph_nxt == PH_BOTH)
            nxt.gb = 1'b1;
        else if (adv && ph_nxt == PH_GSTB && gate_cut)
            nxt.gb = 1'b0;
    end

    // Line register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lines <= LINES_RESET;
        else
            lines <= nxt;
    end

    // One-cycle pulse when the final hold-low segment ends.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done <= 1'b0;
        else
            done <= adv && (ph == PH_HOLDL);
    end

endmodule

// File: rtl/lsq_readout_seq.sv
// Line sensor readout sequencer top. It ties together the phase sequencer,
// the segment timer, the pixel counter and the registered line driver.
// Assumes STROBE_CYC < TICK_CYC and GATE_B_GROUPS < PIXELS.
module lsq_readout_seq
    import lsq_pkg::*;
#(
    parameter int TICK_CYC      = 525,
    parameter int STROBE_CYC    = 50,
    parameter int PIXELS        = 128,
    parameter int GATE_B_GROUPS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic sns_rst,
    output logic gate_a,
    output logic gate_b,
    output logic shift_clk,
    output logic adc_go,
    output logic hold,
    output logic done
);

    localparam int CW = $clog2(16 * TICK_CYC + 1);

    phase_e        ph;
    phase_e        ph_nxt;
    logic          adv;
    logic [CW-1:0] load_val;
    logic          expire;
    logic          pix_last;
    logic          gate_cut;
    logic          pix_preload;
    logic          pix_step;
    lines_t        lines;

    assign pix_preload = adv && (ph_nxt == PH_INIT);
    assign pix_step    = adv && (ph_nxt == PH_GSTB);

    lsq_phase_fsm #(
        .TICK_CYC  (TICK_CYC),
        .STROBE_CYC(STROBE_CYC),
        .CW        (CW)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .expire  (expire),
        .pix_last(pix_last),
        .ph      (ph),
        .ph_nxt  (ph_nxt),
        .adv     (adv),
        .load_val(load_val)
    );

    lsq_tick_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (adv),
        .load_val(load_val),
        .expire  (expire)
    );

    lsq_pixel_counter #(
        .PIXELS       (PIXELS),
        .GATE_B_GROUPS(GATE_B_GROUPS)
    ) u_pix (
        .clk     (clk),
        .rst_n   (rst_n),
        .preload (pix_preload),
        .step    (pix_step),
        .last    (pix_last),
        .gate_cut(gate_cut)
    );

    lsq_line_driver u_drv (
        .clk     (clk),
        .rst_n   (rst_n),
        .ph      (ph),
        .ph_nxt  (ph_nxt),
        .adv     (adv),
        .gate_cut(gate_cut),
        .lines   (lines),
        .done    (done)
    );

    assign sns_rst   = lines.rst;
    assign gate_a    = lines.ga;
    assign gate_b    = lines.gb;
    assign shift_clk = lines.sclk;
    assign adc_go    = lines.adc;
    assign hold      = lines.hold;

endmodule

// File: rtl/lsq_readout_seq_chk.sv
// Checker for the readout sequencer ports. It uses run-length counters
// to check pulse widths, so no long $past windows are needed.
module lsq_readout_seq_chk #(
    parameter int TICK_CYC   = 525,
    parameter int STROBE_CYC = 50
) (
    input logic clk,
    input logic rst_n,
    input logic sns_rst,
    input logic gate_a,
    input logic gate_b,
    input logic shift_clk,
    input logic adc_go,
    input logic hold,
    input logic done
);

    logic [31:0] adc_run;
    logic [31:0] low_run;

    // Length of the current strobe and shift-clock low runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adc_run <= '0;
            low_run <= '0;
        end else begin
            adc_run <= adc_go ? adc_run + 1 : '0;
            low_run <= !shift_clk ? low_run + 1 : '0;
        end
    end

    assert_gates_paired_R3: assert property (@(posedge clk) disable iff (!rst_n)
        gate_a |-> gate_b);
    assert_gates_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_a) |-> $rose(gate_b));
    assert_clk_low_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_clk |-> (low_run < TICK_CYC));
    assert_clk_low_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shift_clk) |-> (low_run == TICK_CYC));
    assert_strobe_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
        adc_go |-> (adc_run < STROBE_CYC));
    assert_strobe_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_go) |-> (adc_run == STROBE_CYC));
    assert_reset_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sns_rst) |-> (!gate_a && !gate_b && !hold && shift_clk));
    assert_hold_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (!gate_a && !gate_b && !adc_go && shift_clk));
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sns_rst && shift_clk && !hold));

endmodule

bind lsq_readout_seq lsq_readout_seq_chk #(
    .TICK_CYC  (TICK_CYC),
    .STROBE_CYC(STROBE_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sns_rst  (sns_rst),
    .gate_a   (gate_a),
    .gate_b   (gate_b),
    .shift_clk(shift_clk),
    .adc_go   (adc_go),
    .hold     (hold),
    .done     (done)
);

// File: tb/lsq_readout_seq_test.sv
`timescale 1ns/1ps
module lsq_readout_seq_test;

    localparam int T = 8;
    localparam int S = 3;
    localparam int P = 128;
    localparam int G = 11;
    localparam int FRAME = (57 + 8 * P) * T;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic sns_rst, gate_a, gate_b, shift_clk, adc_go, hold, done;

    always #2 clk = ~clk;

    lsq_readout_seq #(
        .TICK_CYC(T), .STROBE_CYC(S), .PIXELS(P), .GATE_B_GROUPS(G)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .sns_rst(sns_rst), .gate_a(gate_a), .gate_b(gate_b),
        .shift_clk(shift_clk), .adc_go(adc_go), .hold(hold), .done(done)
    );

    // Expected edge: signal id (0 rst,1 ga,2 gb,3 sclk,4 adc,5 hold,6 done), new value, offset.
    typedef struct packed {
        logic [2:0]  sig;
        logic        val;
        logic [31:0] t;
    } ev_t;

    ev_t     exp_q[$];
    int      n_run = 0;
    int      n_fail = 0;
    longint  ncyc = 0;
    longint  t0 = 0;
    bit      mon_en = 1'b0;
    int      adc_cnt = 0;
    longint  done_at = -1;
    logic [6:0] prev = 7'b0001000;

    function automatic string tag(input logic [2:0] s);
        case (s)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R7";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic push(input int s, input bit v, input longint t);
        ev_t e;
        e.sig = 3'(s);
        e.val = v;
        e.t   = 32'(t);
        exp_q.push_back(e);
    endtask

    // Driver: predicted edge list of one frame, offsets from the start edge.
    task automatic expect_frame(input bit after_frame);
        longint g;
        longint tt;
        if (after_frame) push(0, 1'b0, 0);              // R12 rerun clears reset
        push(0, 1'b1, 2 * T);                            // R2
        push(1, 1'b1, 8 * T);                            // R3
        push(2, 1'b1, 8 * T);
        push(1, 1'b0, 16 * T);
        push(3, 1'b0, 24 * T); push(3, 1'b1, 25 * T);    // R4 plain pulses
        push(3, 1'b0, 28 * T); push(3, 1'b1, 29 * T);
        for (int i = 0; i < P; i++) begin
            g = 32 * T + 8 * T * i;
            if (i == G) push(2, 1'b0, g);                // R7
            push(3, 1'b0, g);
            push(4, 1'b1, g);                            // R5
            push(4, 1'b0, g + S);
            push(3, 1'b1, g + T);
            push(3, 1'b0, g + 4 * T);
            push(3, 1'b1, g + 5 * T);
        end
        tt = 32 * T + 8 * T * P;
        push(4, 1'b1, tt); push(4, 1'b0, tt + S);        // R8 trailing strobe
        push(5, 1'b1, tt + 17 * T);
        push(5, 1'b0, tt + 21 * T);
        push(6, 1'b1, tt + 25 * T);                      // R9
        push(6, 1'b0, tt + 25 * T + 1);
    endtask

    task automatic launch();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        t0 = ncyc + 1;
        adc_cnt = 0;
        done_at = -1;
    endtask

    // Wait for done, then check count, length and that all edges were seen.
    task automatic finish_frame(input string name);
        for (int i = 0; i < FRAME + 200 && done_at < 0; i++) @(posedge clk);
        repeat (4) @(posedge clk);
        #1;
        check(done_at == FRAME, "R10", {name, " frame length"}, done_at, FRAME);
        check(adc_cnt == P + 1, "R6", {name, " strobe count"}, adc_cnt, P + 1);
        check(exp_q.size() == 0, "R10", {name, " missing edges"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic check_reset_state(input string name);
        check(sns_rst == 1'b0, "R1", {name, " sns_rst"}, sns_rst, 0);
        check(gate_a == 1'b0, "R1", {name, " gate_a"}, gate_a, 0);
        check(gate_b == 1'b0, "R1", {name, " gate_b"}, gate_b, 0);
        check(shift_clk == 1'b1, "R1", {name, " shift_clk"}, shift_clk, 1);
        check(adc_go == 1'b0, "R1", {name, " adc_go"}, adc_go, 0);
        check(hold == 1'b0, "R1", {name, " hold"}, hold, 0);
        check(done == 1'b0, "R1", {name, " done"}, done, 0);
    endtask

    // Monitor: detect output edges, pop and compare against the scoreboard.
    always @(negedge clk) begin
        logic [6:0] cur;
        ev_t e;
        ncyc++;
        cur = {done, hold, adc_go, shift_clk, gate_b, gate_a, sns_rst};
        if (mon_en) begin
            for (int s = 0; s < 7; s++) begin
                if (cur[s] != prev[s]) begin
                    if (s == 4 && cur[s]) adc_cnt++;
                    if (s == 6 && cur[s]) done_at = ncyc - t0;
                    if (exp_q.size() == 0) begin
                        check(1'b0, tag(3'(s)), "unexpected edge at offset",
                              ncyc - t0, -1);
                    end else begin
                        e = exp_q.pop_front();
                        check(e.sig == 3'(s) && e.val == cur[s], tag(e.sig),
                              "edge signal id", s, e.sig);
                        check(longint'(e.t) == ncyc - t0, tag(e.sig),
                              "edge offset", ncyc - t0, e.t);
                    end
                end
            end
        end
        prev = cur;
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog expired: actual %0d expected %0d", 150000, 4 * FRAME);
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 check_reset_state("reset");
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1 mon_en = 1'b1;

        // Frame 1 after reset.
        expect_frame(1'b0);
        launch();
        finish_frame("first");

        // Frame 2: rerun (R12) with a stray start in mid-frame (R11).
        repeat (10) @(posedge clk);
        expect_frame(1'b1);
        launch();
        repeat (3000) @(posedge clk);
        #1 start = 1'b1;
        repeat (5) @(posedge clk);
        #1 start = 1'b0;
        finish_frame("R11 stray start");

        // Frame 3: reset in mid-frame returns the lines to rest (R1).
        mon_en = 1'b0;
        launch();
        repeat (700) @(posedge clk);
        #1 rst_n = 1'b0;
        @(posedge clk);
        #1 check_reset_state("R1 mid-frame reset");
        rst_n = 1'b1;
        exp_q.delete();
        @(posedge clk);
        #1 mon_en = 1'b1;
        repeat (50) @(posedge clk);   // idle: any edge is unexpected

        // Frame 4 after mid-frame reset.
        expect_frame(1'b0);
        launch();
        finish_frame("after reset");

        summary();
        $finish;
    end

endmodule